// File: doc/BRIEF.md
# Speculative and Committed Register State Keeper

This block keeps two copies of a small register set for an in-order issue, out-of-order completion pipeline. The speculative copy is updated the moment a result comes back and is the only place decode reads operands from. The committed copy changes only when the oldest in-flight instruction retires cleanly, so it always matches program order. A small circular queue tracks in-flight instructions. It holds each result until that instruction is the oldest, and then writes it to the committed copy.

Each speculative entry holds a value, a tag and a valid flag. When decode allocates an instruction that has a destination, the queue slot number becomes the destination's tag and the entry is marked pending. A completing result is written to the speculative copy only while its tag is still the one recorded there, that is, while it is still the youngest writer of that register. Any completion also marks its queue slot done. A faulting instruction, or a branch flagged as mispredicted, is handled only once it reaches the head of the queue. At that point the controller spends one cycle in recovery. During that cycle it signals a flush, copies the whole committed set into the speculative set, and empties the queue.

The controller has two states. `ST_RUN` is normal operation: it allocates, completes and retires. `ST_RECOVER` is the single flush-and-copy cycle. Transition `head_fault` goes from `ST_RUN` to `ST_RECOVER` when the head slot is done and carries an exception or a misprediction mark. Transition `copy_done` returns from `ST_RECOVER` to `ST_RUN` unconditionally one cycle later.

Top module: `dual_regfile_recovery`

## Requirements
- R1: After reset every speculative entry reads valid with value 0 and tag 0, every committed entry is 0, the queue is empty, and `dec_ready` is 1.
- R2: An accepted allocation (`dec_valid` and `dec_ready`) returns `dec_tag`, which is the allocation count since reset or the last recovery, modulo DEPTH. If `dec_has_dest` is 1, the destination entry reads invalid with that tag from the next cycle. The source read ports show the speculative entry combinationally.
- R3: A completion writes its value to the speculative entry and marks it valid only if that entry is pending with a tag equal to `cpl_tag`. A completion from an older writer whose tag has since been replaced leaves the entry unchanged.
- R4: Queue slots retire strictly in allocation order, at most one per cycle, in the cycle after the head slot is done. A retirement with a destination and no exception raises `ret_valid` with its register and value and writes the committed entry.
- R5: The queue holds DEPTH instructions. With DEPTH in flight `dec_ready` is 0, and an allocation attempt changes neither the speculative set nor the next tag.
- R6: A head slot completed with `cpl_exc` = 1 retires without writing the committed set. One cycle later `flush_valid` and `flush_to_handler` are both 1.
- R7: `mis_valid` marks the slot `mis_tag`. No flush happens until that slot is the oldest and done. It then retires normally, and in the next cycle `flush_valid` is 1 with `flush_to_handler` 0.
- R8: In the recovery cycle `dec_ready` is 0. After it, every speculative entry holds the committed value, valid, with tag 0. The queue is empty, and the next allocation receives tag 0.
- R9: `flush_valid` lasts exactly one cycle and is never high together with `ret_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode requests a queue slot |
| dec_has_dest | input | 1 | Allocated instruction writes a register |
| dec_dest | input | RW | Destination register index |
| dec_ready | output | 1 | Allocation accepted this cycle |
| dec_tag | output | TW | Tag given to the allocation |
| src_a_idx | input | RW | Operand read port A index |
| src_a_data | output | DW | Port A speculative value |
| src_a_valid | output | 1 | Port A value present |
| src_a_tag | output | TW | Port A pending producer tag |
| src_b_idx | input | RW | Operand read port B index |
| src_b_data | output | DW | Port B speculative value |
| src_b_valid | output | 1 | Port B value present |
| src_b_tag | output | TW | Port B pending producer tag |
| cpl_valid | input | 1 | A result completes |
| cpl_tag | input | TW | Slot of the completing instruction |
| cpl_data | input | DW | Result value |
| cpl_exc | input | 1 | Completing instruction faulted |
| mis_valid | input | 1 | A branch was found mispredicted |
| mis_tag | input | TW | Slot of the mispredicted branch |
| ret_valid | output | 1 | A committed register write this cycle |
| ret_dest | output | RW | Committed register index |
| ret_data | output | DW | Committed value |
| flush_valid | output | 1 | Recovery cycle: pipeline flush |
| flush_to_handler | output | 1 | Flush is for an exception, not a misprediction |

## Verification
The assertions assume that `cpl_tag` and `mis_tag` only name slots that are currently allocated, that each slot completes once, and that `dec_valid` is not raised while `dec_ready` is low except as an intentional probe. The bench keeps to this by recording every tag the block returns and completing or marking only those tags, each once. It always waits for recovery to finish before reusing tags, and its one deliberate allocation attempt against a full queue is made while `dec_ready` is observed low.

// File: rtl/dual_regfile_pkg.sv
package dual_regfile_pkg;
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/spec_regfile.sv
module spec_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int TW   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [$clog2(NREG)-1:0] rd_idx_a,
    output logic [DW-1:0]       rd_data_a,
    output logic                rd_valid_a,
    output logic [TW-1:0]       rd_tag_a,
    input  logic [$clog2(NREG)-1:0] rd_idx_b,
    output logic [DW-1:0]       rd_data_b,
    output logic                rd_valid_b,
    output logic [TW-1:0]       rd_tag_b,
    input  logic                set_en,
    input  logic [$clog2(NREG)-1:0] set_idx,
    input  logic [TW-1:0]       set_tag,
    input  logic                wb_en,
    input  logic [TW-1:0]       wb_tag,
    input  logic [DW-1:0]       wb_data,
    input  logic                load_en,
    input  logic [NREG*DW-1:0]  load_data
);
    localparam int RW = $clog2(NREG);

    logic [DW-1:0] val_arr [NREG];
    logic          vld_arr [NREG];
    logic [TW-1:0] tag_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] val_q;
        logic          vld_q;
        logic [TW-1:0] tag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
                vld_q <= 1'b1;
                tag_q <= '0;
            end else if (load_en) begin
                val_q <= load_data[g*DW +: DW];
                vld_q <= 1'b1;
                tag_q <= '0;
            end else if (set_en && set_idx == RW'(g)) begin
                vld_q <= 1'b0;
                tag_q <= set_tag;
            end else if (wb_en && !vld_q && tag_q == wb_tag) begin
                val_q <= wb_data;
                vld_q <= 1'b1;
            end
        end

        assign val_arr[g] = val_q;
        assign vld_arr[g] = vld_q;
        assign tag_arr[g] = tag_q;
    end

    assign rd_data_a  = val_arr[rd_idx_a];
    assign rd_valid_a = vld_arr[rd_idx_a];
    assign rd_tag_a   = tag_arr[rd_idx_a];
    assign rd_data_b  = val_arr[rd_idx_b];
    assign rd_valid_b = vld_arr[rd_idx_b];
    assign rd_tag_b   = tag_arr[rd_idx_b];
endmodule

// File: rtl/arch_regfile.sv
module arch_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    output logic [NREG*DW-1:0]      all_data
);
    localparam int RW = $clog2(NREG);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && wr_idx == RW'(g)) begin
                val_q <= wr_data;
            end
        end

        assign all_data[g*DW +: DW] = val_q;
    end
endmodule

// File: rtl/retire_queue.sv
module retire_queue #(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int RW    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_en,
    input  logic                     push_en,
    input  logic [RW-1:0]            push_dest,
    input  logic                     push_has_dest,
    output logic [$clog2(DEPTH)-1:0] tail_tag,
    output logic                     full,
    input  logic                     done_en,
    input  logic [$clog2(DEPTH)-1:0] done_tag,
    input  logic [DW-1:0]            done_data,
    input  logic                     done_exc,
    input  logic                     mark_en,
    input  logic [$clog2(DEPTH)-1:0] mark_tag,
    input  logic                     pop_en,
    output logic                     head_ready,
    output logic [RW-1:0]            head_dest,
    output logic                     head_has_dest,
    output logic [DW-1:0]            head_data,
    output logic                     head_exc,
    output logic                     head_mark
);
    localparam int TW = $clog2(DEPTH);

    logic [TW:0]   head_q, tail_q;
    logic [TW-1:0] head_idx, tail_idx;

    logic          busy_arr [DEPTH];
    logic          done_arr [DEPTH];
    logic          hasd_arr [DEPTH];
    logic          exc_arr  [DEPTH];
    logic          mark_arr [DEPTH];
    logic [RW-1:0] dest_arr [DEPTH];
    logic [DW-1:0] data_arr [DEPTH];

    assign head_idx = head_q[TW-1:0];
    assign tail_idx = tail_q[TW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (clear_en) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push_en) tail_q <= tail_q + 1'b1;
            if (pop_en)  head_q <= head_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic          busy_q, done_q, hasd_q, exc_q, mark_q;
        logic [RW-1:0] dest_q;
        logic [DW-1:0] data_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
                hasd_q <= 1'b0;
                exc_q  <= 1'b0;
                mark_q <= 1'b0;
                dest_q <= '0;
                data_q <= '0;
            end else if (clear_en) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
                mark_q <= 1'b0;
            end else if (push_en && tail_idx == TW'(g)) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
                mark_q <= 1'b0;
                hasd_q <= push_has_dest;
                dest_q <= push_dest;
                data_q <= '0;
            end else begin
                if (pop_en && head_idx == TW'(g)) busy_q <= 1'b0;
                if (done_en && busy_q && done_tag == TW'(g)) begin
                    done_q <= 1'b1;
                    data_q <= done_data;
                    exc_q  <= done_exc;
                end
                if (mark_en && busy_q && mark_tag == TW'(g)) mark_q <= 1'b1;
            end
        end

        assign busy_arr[g] = busy_q;
        assign done_arr[g] = done_q;
        assign hasd_arr[g] = hasd_q;
        assign exc_arr[g]  = exc_q;
        assign mark_arr[g] = mark_q;
        assign dest_arr[g] = dest_q;
        assign data_arr[g] = data_q;
    end

    assign tail_tag      = tail_idx;
    assign full          = (head_q[TW] != tail_q[TW]) && (head_idx == tail_idx);
    assign head_ready    = busy_arr[head_idx] && done_arr[head_idx];
    assign head_dest     = dest_arr[head_idx];
    assign head_has_dest = hasd_arr[head_idx];
    assign head_data     = data_arr[head_idx];
    assign head_exc      = exc_arr[head_idx];
    assign head_mark     = mark_arr[head_idx];
endmodule

// File: rtl/dual_regfile_recovery.sv
module dual_regfile_recovery
    import dual_regfile_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int RW   = $clog2(NREG),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          dec_has_dest,
    input  logic [RW-1:0] dec_dest,
    output logic          dec_ready,
    output logic [TW-1:0] dec_tag,
    input  logic [RW-1:0] src_a_idx,
    output logic [DW-1:0] src_a_data,
    output logic          src_a_valid,
    output logic [TW-1:0] src_a_tag,
    input  logic [RW-1:0] src_b_idx,
    output logic [DW-1:0] src_b_data,
    output logic          src_b_valid,
    output logic [TW-1:0] src_b_tag,
    input  logic          cpl_valid,
    input  logic [TW-1:0] cpl_tag,
    input  logic [DW-1:0] cpl_data,
    input  logic          cpl_exc,
    input  logic          mis_valid,
    input  logic [TW-1:0] mis_tag,
    output logic          ret_valid,
    output logic [RW-1:0] ret_dest,
    output logic [DW-1:0] ret_data,
    output logic          flush_valid,
    output logic          flush_to_handler
);
    ctl_state_e state_q, state_d;
    logic       handler_q;

    logic          q_full, head_ready, head_has_dest, head_exc, head_mark;
    logic [RW-1:0] head_dest;
    logic [DW-1:0] head_data;
    logic [NREG*DW-1:0] committed;

    logic run_mode, dec_fire, pop_en, restore_en;

    assign run_mode = (state_q == ST_RUN);
    assign dec_fire = dec_valid && dec_ready;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (head_ready && (head_exc || head_mark)) state_d = ST_RECOVER; // head_fault
            ST_RECOVER: state_d = ST_RUN;                                              // copy_done
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Flush cause captured when the head faults
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        handler_q <= 1'b0;
        else if (run_mode && head_ready && (head_exc || head_mark)) handler_q <= head_exc;
    end

    // Output process
    always_comb begin
        dec_ready   = 1'b0;
        ret_valid   = 1'b0;
        pop_en      = 1'b0;
        flush_valid = 1'b0;
        restore_en  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                dec_ready = !q_full;
                pop_en    = head_ready;
                ret_valid = head_ready && head_has_dest && !head_exc;
            end
            ST_RECOVER: begin
                flush_valid = 1'b1;
                restore_en  = 1'b1;
            end
        endcase
    end

    assign flush_to_handler = flush_valid && handler_q;
    assign ret_dest         = head_dest;
    assign ret_data         = head_data;

    retire_queue #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_en      (restore_en),
        .push_en       (dec_fire),
        .push_dest     (dec_dest),
        .push_has_dest (dec_has_dest),
        .tail_tag      (dec_tag),
        .full          (q_full),
        .done_en       (cpl_valid && run_mode),
        .done_tag      (cpl_tag),
        .done_data     (cpl_data),
        .done_exc      (cpl_exc),
        .mark_en       (mis_valid && run_mode),
        .mark_tag      (mis_tag),
        .pop_en        (pop_en),
        .head_ready    (head_ready),
        .head_dest     (head_dest),
        .head_has_dest (head_has_dest),
        .head_data     (head_data),
        .head_exc      (head_exc),
        .head_mark     (head_mark)
    );

    spec_regfile #(.NREG(NREG), .DW(DW), .TW(TW)) u_spec (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_a   (src_a_idx),
        .rd_data_a  (src_a_data),
        .rd_valid_a (src_a_valid),
        .rd_tag_a   (src_a_tag),
        .rd_idx_b   (src_b_idx),
        .rd_data_b  (src_b_data),
        .rd_valid_b (src_b_valid),
        .rd_tag_b   (src_b_tag),
        .set_en     (dec_fire && dec_has_dest),
        .set_idx    (dec_dest),
        .set_tag    (dec_tag),
        .wb_en      (cpl_valid && run_mode),
        .wb_tag     (cpl_tag),
        .wb_data    (cpl_data),
        .load_en    (restore_en),
        .load_data  (committed)
    );

    arch_regfile #(.NREG(NREG), .DW(DW)) u_arch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ret_valid),
        .wr_idx   (head_dest),
        .wr_data  (head_data),
        .all_data (committed)
    );
endmodule

// File: rtl/dual_regfile_recovery_checks.sv
module dual_regfile_recovery_checks #(
    parameter int RW = 3,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid,
    input logic          dec_ready,
    input logic          dec_has_dest,
    input logic [RW-1:0] dec_dest,
    input logic [TW-1:0] dec_tag,
    input logic [RW-1:0] src_a_idx,
    input logic          src_a_valid,
    input logic [TW-1:0] src_a_tag,
    input logic          src_b_valid,
    input logic [TW-1:0] src_b_tag,
    input logic          ret_valid,
    input logic          flush_valid
);
    assert_flush_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !flush_valid);

    assert_flush_no_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !ret_valid);

    assert_decode_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !dec_ready);

    assert_queue_emptied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> dec_ready);

    assert_spec_restored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (src_a_valid && src_a_tag == '0 && src_b_valid && src_b_tag == '0));

    assert_alloc_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready && dec_has_dest && dec_dest == src_a_idx)
        |=> ($stable(src_a_idx) -> (!src_a_valid && src_a_tag == $past(dec_tag))));
endmodule

bind dual_regfile_recovery dual_regfile_recovery_checks #(.RW(RW), .TW(TW)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_ready    (dec_ready),
    .dec_has_dest (dec_has_dest),
    .dec_dest     (dec_dest),
    .dec_tag      (dec_tag),
    .src_a_idx    (src_a_idx),
    .src_a_valid  (src_a_valid),
    .src_a_tag    (src_a_tag),
    .src_b_valid  (src_b_valid),
    .src_b_tag    (src_b_tag),
    .ret_valid    (ret_valid),
    .flush_valid  (flush_valid)
);

// File: tb/dual_regfile_recovery_test.sv
`timescale 1ns/1ps
module dual_regfile_recovery_test;
    localparam int NREG = 8, DW = 16, DEPTH = 4, RW = 3, TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic dec_valid, dec_has_dest, dec_ready;
    logic [RW-1:0] dec_dest, src_a_idx, src_b_idx, ret_dest;
    logic [TW-1:0] dec_tag, src_a_tag, src_b_tag, cpl_tag, mis_tag;
    logic [DW-1:0] src_a_data, src_b_data, cpl_data, ret_data;
    logic src_a_valid, src_b_valid, cpl_valid, cpl_exc, mis_valid;
    logic ret_valid, flush_valid, flush_to_handler;

    dual_regfile_recovery #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH)) uut (.*);

    int checks = 0, fails = 0, ret_n = 0, flush_n = 0, alloc_ct = 0;
    bit finished = 1'b0, last_handler = 1'b0;
    logic [DW-1:0] arch_m [NREG];
    logic [RW-1:0] log_dest [64];
    logic [DW-1:0] log_data [64];

    always @(negedge clk) if (rst_n) begin
        if (ret_valid && ret_n < 64) begin
            log_dest[ret_n] = ret_dest;
            log_data[ret_n] = ret_data;
            ret_n++;
        end
        if (flush_valid) begin
            flush_n++;
            last_handler = flush_to_handler;
        end
    end

    task automatic check_eq(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] val(int a, int b);
        return DW'(a * 4099 + b * 77 + 3);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input int r, input bit hd, output logic [TW-1:0] t);
        dec_valid = 1'b1; dec_has_dest = hd; dec_dest = RW'(r);
        t = dec_tag;
        check_eq("R2 tag", 32'(t), 32'(alloc_ct % DEPTH));
        alloc_ct++;
        tick();
        dec_valid = 1'b0;
    endtask

    task automatic complete(input logic [TW-1:0] t, input logic [DW-1:0] d, input bit ex);
        cpl_valid = 1'b1; cpl_tag = t; cpl_data = d; cpl_exc = ex;
        tick();
        cpl_valid = 1'b0; cpl_exc = 1'b0;
    endtask

    task automatic mispredict(input logic [TW-1:0] t);
        mis_valid = 1'b1; mis_tag = t;
        tick();
        mis_valid = 1'b0;
    endtask

    task automatic rd(input int r, output logic [DW-1:0] d, output logic v, output logic [TW-1:0] t);
        src_a_idx = RW'(r);
        src_b_idx = RW'(NREG - 1 - r);
        @(negedge clk);
        d = src_a_data; v = src_a_valid; t = src_a_tag;
    endtask

    task automatic expect_val(string req, int r, logic [DW-1:0] e);
        logic [DW-1:0] d; logic v; logic [TW-1:0] t;
        rd(r, d, v, t);
        check_eq({req, " valid"}, 32'(v), 32'd1);
        check_eq({req, " data"}, 32'(d), 32'(e));
    endtask

    task automatic expect_pending(string req, int r, logic [TW-1:0] e);
        logic [DW-1:0] d; logic v; logic [TW-1:0] t;
        rd(r, d, v, t);
        check_eq({req, " valid"}, 32'(v), 32'd0);
        check_eq({req, " tag"}, 32'(t), 32'(e));
    endtask

    task automatic expect_clean(string req, int r, logic [DW-1:0] e);
        logic [DW-1:0] d; logic v; logic [TW-1:0] t;
        rd(r, d, v, t);
        check_eq({req, " valid"}, 32'(v), 32'd1);
        check_eq({req, " data"}, 32'(d), 32'(e));
        check_eq({req, " tag"}, 32'(t), 32'd0);
    endtask

    task automatic expect_log(string req, int idx, int r, logic [DW-1:0] d);
        check_eq({req, " dest"}, 32'(log_dest[idx]), 32'(r));
        check_eq({req, " data"}, 32'(log_data[idx]), 32'(d));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] t, t1, t2, tq [4];
        int base, fbase, rbase;
        dec_valid = 0; dec_has_dest = 0; dec_dest = '0;
        src_a_idx = '0; src_b_idx = '0;
        cpl_valid = 0; cpl_tag = '0; cpl_data = '0; cpl_exc = 0;
        mis_valid = 0; mis_tag = '0;
        for (int r = 0; r < NREG; r++) arch_m[r] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state of every entry
        check_eq("R1 ready", 32'(dec_ready), 32'd1);
        for (int r = 0; r < NREG; r++) expect_clean("R1", r, '0);

        // R2 R3 R4: sweep every register through allocate, complete, retire
        for (int r = 0; r < NREG; r++) begin
            alloc(r, 1'b1, t);
            expect_pending("R2", r, t);
            complete(t, val(1, r), 1'b0);
            expect_val("R3", r, val(1, r));
            tick(); tick();
            expect_log("R4 sweep", ret_n - 1, r, val(1, r));
            arch_m[r] = val(1, r);
        end

        // R3: younger completes first, older result must not overwrite
        alloc(2, 1'b1, t1); alloc(2, 1'b1, t2);
        complete(t2, val(2, 1), 1'b0);
        expect_val("R3 younger", 2, val(2, 1));
        complete(t1, val(2, 2), 1'b0);
        expect_val("R3 stale ignored", 2, val(2, 1));
        tick(); tick(); tick();
        expect_log("R4 order", ret_n - 2, 2, val(2, 2));
        expect_log("R4 order", ret_n - 1, 2, val(2, 1));
        arch_m[2] = val(2, 1);

        // R3: older completes first, entry stays pending for the younger tag
        alloc(3, 1'b1, t1); alloc(3, 1'b1, t2);
        complete(t1, val(3, 1), 1'b0);
        expect_pending("R3 older first", 3, t2);
        complete(t2, val(3, 2), 1'b0);
        expect_val("R3 youngest lands", 3, val(3, 2));
        tick(); tick(); tick();
        arch_m[3] = val(3, 2);

        // R5 R4: fill the queue, probe a blocked allocation, reverse completion
        base = ret_n;
        for (int k = 0; k < 4; k++) alloc(4 + k, 1'b1, tq[k]);
        check_eq("R5 full", 32'(dec_ready), 32'd0);
        dec_valid = 1'b1; dec_has_dest = 1'b1; dec_dest = '0;
        tick();
        dec_valid = 1'b0;
        expect_val("R5 blocked alloc", 0, arch_m[0]);
        for (int k = 3; k >= 1; k--) complete(tq[k], val(4, k), 1'b0);
        check_eq("R4 waits for head", 32'(ret_n), 32'(base));
        complete(tq[0], val(4, 0), 1'b0);
        repeat (5) tick();
        for (int k = 0; k < 4; k++) begin
            expect_log("R4 reverse completion", base + k, 4 + k, val(4, k));
            arch_m[4 + k] = val(4, k);
        end
        check_eq("R5 ready again", 32'(dec_ready), 32'd1);

        // R6 R8: exception at head, younger speculative update undone
        fbase = flush_n; rbase = ret_n;
        alloc(1, 1'b1, t1); alloc(0, 1'b1, t2);
        complete(t2, val(5, 0), 1'b0);
        expect_val("R3 speculative", 0, val(5, 0));
        complete(t1, val(5, 1), 1'b1);
        tick();
        check_eq("R6 flush", 32'(flush_valid), 32'd1);
        check_eq("R6 handler", 32'(flush_to_handler), 32'd1);
        check_eq("R8 decode blocked", 32'(dec_ready), 32'd0);
        tick();
        check_eq("R9 pulse", 32'(flush_valid), 32'd0);
        check_eq("R6 no commit", 32'(ret_n), 32'(rbase));
        check_eq("R6 flush count", 32'(flush_n), 32'(fbase + 1));
        for (int r = 0; r < NREG; r++) expect_clean("R8 restore", r, arch_m[r]);
        alloc_ct = 0;

        // R7: mispredicted branch at head
        fbase = flush_n; rbase = ret_n;
        alloc(0, 1'b0, t1);
        alloc(6, 1'b1, t2);
        complete(t2, val(6, 6), 1'b0);
        expect_val("R3 wrong path", 6, val(6, 6));
        mispredict(t1);
        tick(); tick();
        check_eq("R7 waits for done", 32'(flush_n), 32'(fbase));
        complete(t1, '0, 1'b0);
        tick();
        check_eq("R7 flush", 32'(flush_valid), 32'd1);
        check_eq("R7 cause", 32'(flush_to_handler), 32'd0);
        tick();
        expect_clean("R8 restore", 6, arch_m[6]);
        check_eq("R7 branch no commit", 32'(ret_n), 32'(rbase));
        alloc_ct = 0;

        // R7: branch behind an unfinished older instruction
        fbase = flush_n;
        alloc(5, 1'b1, tq[0]);
        alloc(0, 1'b0, tq[1]);
        alloc(4, 1'b1, tq[2]);
        complete(tq[1], '0, 1'b0);
        mispredict(tq[1]);
        complete(tq[2], val(7, 4), 1'b0);
        tick(); tick();
        check_eq("R7 waits for oldest", 32'(flush_n), 32'(fbase));
        complete(tq[0], val(7, 5), 1'b0);
        repeat (4) tick();
        check_eq("R7 flush after older", 32'(flush_n), 32'(fbase + 1));
        check_eq("R7 cause", 32'(last_handler), 32'd0);
        expect_log("R4 older commits", ret_n - 1, 5, val(7, 5));
        arch_m[5] = val(7, 5);
        for (int r = 0; r < NREG; r++) expect_clean("R8 final", r, arch_m[r]);
        alloc_ct = 0;
        alloc(1, 1'b1, t);
        complete(t, val(8, 1), 1'b0);
        tick(); tick();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule